// File: doc/BRIEF.md
# Watchdog Timer with Early Warning

This block guards against software that stops making progress. A counter advances once per pulse of a slow, calibrated 1 kHz tick. After software enables the block, it must restart the counter from time to time. If software misses a restart, the block raises a one-cycle non-maskable interrupt request as an early warning at 1792 ticks. At 2048 ticks it raises a one-cycle reset request for the reset generator.

The block comes out of reset disabled, so nothing counts until software enables it. A disable request stops the counter and clears it. Saving and restoring the watchdog around deep sleep is done from outside with these same disable and enable requests. While a debugger holds the processor halted, the debug-halt input freezes the count, so a breakpoint does not cause a false expiry.

Top module: `wdt_early_warn`

## Requirements
- R1: After reset the block is disabled. The count reads 0 and both request outputs are low. Ticks have no effect until an enable request arrives.
- R2: While enabled, the count rises by exactly one at each clock edge that samples the tick input high with debug-halt low. On edges with the tick low, the count holds.
- R3: The early-warning output is high for exactly one cycle: the cycle in which the count first reads 1792 (WARN_TICKS). It stays high in no other cycle of that interval.
- R4: On the tick that would take the count from 2047 to 2048 (EXPIRE_TICKS), the reset request is high for one cycle and the count reads 0 in that same cycle. The block stays enabled and counting resumes.
- R5: A restart strobe while enabled clears the count to 0 on the next edge. A later interval then produces its own early warning, including after a restart given once the warning has fired.
- R6: While debug-halt is high, the count and both request outputs hold, even though ticks keep arriving.
- R7: A disable request clears the count to 0 and stops counting. When enable and disable arrive in the same cycle, disable wins. A later enable request starts counting again from 0.
- R8: A restart strobe while the block is disabled has no effect: the count stays 0 and no request is raised.
- R9: The count never reads a value of EXPIRE_TICKS or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the always-on domain |
| tick_i | input | 1 | One-cycle enable, one pulse per 1 kHz reference period |
| arm_i | input | 1 | Enable request |
| disarm_i | input | 1 | Disable request, takes priority over enable |
| kick_i | input | 1 | Software restart strobe |
| dbg_halt_i | input | 1 | Debugger holds the processor halted; freezes counting |
| nmi_pulse_o | output | 1 | Early-warning non-maskable interrupt request, one cycle |
| rst_req_o | output | 1 | Timeout reset request, one cycle |
| count_o | output | $clog2(EXPIRE_TICKS) | Current count of ticks since the last restart |

## Verification
Every result is a register output, so each result shows in the cycle after the edge that samples its cause. The count changes one edge after a qualifying tick, restart or disable. The early warning rises on the same edge that makes the count read 1792. The reset request rises on the same edge that returns the count to 0. An enable request adds one edge before counting starts, because the edge that samples it does not itself count.

The bench drives its inputs at the falling edge and samples at the next falling edge. After an enable, it works out the expected count as the number of qualifying cycles since that enable. It compares the count and both requests in the exact cycle they are due, and in the cycles on either side of that cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // What the counter does on the coming edge
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_CLEAR = 2'd1,
        ACT_STEP  = 2'd2
    } wdt_act_e;

endpackage

// File: rtl/wdt_ctrl_arb.sv
module wdt_ctrl_arb
    import wdt_pkg::*;
(
    input  logic     running_i,
    input  logic     arm_i,
    input  logic     disarm_i,
    input  logic     kick_i,
    input  logic     tick_i,
    input  logic     halt_i,
    output logic     run_next_o,
    output wdt_act_e act_o
);

    always_comb begin
        // disable outranks enable
        if (disarm_i)      run_next_o = 1'b0;
        else if (arm_i)    run_next_o = 1'b1;
        else               run_next_o = running_i;

        // disable, then restart, then a qualified tick
        if (disarm_i)                               act_o = ACT_CLEAR;
        else if (running_i && kick_i)               act_o = ACT_CLEAR;
        else if (running_i && tick_i && !halt_i)    act_o = ACT_STEP;
        else                                        act_o = ACT_HOLD;
    end

endmodule

// File: rtl/wdt_match.sv
module wdt_match #(
    parameter int W      = 11,
    parameter int THRESH = 1792
) (
    input  logic [W:0] val_i,
    output logic       hit_o
);

    assign hit_o = (val_i == (W+1)'(THRESH));

endmodule

// File: rtl/wdt_early_warn.sv
module wdt_early_warn
    import wdt_pkg::*;
#(
    parameter int WARN_TICKS   = 1792,
    parameter int EXPIRE_TICKS = 2048,
    localparam int CNT_W       = $clog2(EXPIRE_TICKS)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             arm_i,
    input  logic             disarm_i,
    input  logic             kick_i,
    input  logic             dbg_halt_i,
    output logic             nmi_pulse_o,
    output logic             rst_req_o,
    output logic [CNT_W-1:0] count_o
);

    typedef struct packed {
        logic             running;
        logic [CNT_W-1:0] count;
        logic             warn;
        logic             bark;
    } wdt_state_t;

    wdt_state_t st_d, st_q;
    wdt_act_e   act;
    logic       run_next;
    logic [CNT_W:0] inc;
    logic       hit_warn, hit_exp;

    assign inc = {1'b0, st_q.count} + (CNT_W+1)'(1);

    wdt_ctrl_arb u_arb (
        .running_i  (st_q.running),
        .arm_i      (arm_i),
        .disarm_i   (disarm_i),
        .kick_i     (kick_i),
        .tick_i     (tick_i),
        .halt_i     (dbg_halt_i),
        .run_next_o (run_next),
        .act_o      (act)
    );

    wdt_match #(.W(CNT_W), .THRESH(WARN_TICKS)) u_warn_cmp (
        .val_i (inc),
        .hit_o (hit_warn)
    );

    wdt_match #(.W(CNT_W), .THRESH(EXPIRE_TICKS)) u_exp_cmp (
        .val_i (inc),
        .hit_o (hit_exp)
    );

    always_comb begin
        st_d         = st_q;
        st_d.running = run_next;
        st_d.warn    = 1'b0;
        st_d.bark    = 1'b0;
        unique case (act)
            ACT_CLEAR: st_d.count = '0;
            ACT_STEP: begin
                if (hit_exp) begin
                    st_d.count = '0;
                    st_d.bark  = 1'b1;
                end else begin
                    st_d.count = inc[CNT_W-1:0];
                    st_d.warn  = hit_warn;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign nmi_pulse_o = st_q.warn;
    assign rst_req_o   = st_q.bark;
    assign count_o     = st_q.count;

endmodule

// File: rtl/wdt_chk.sv
module wdt_chk #(
    parameter int CNT_W  = 11,
    parameter int WARN   = 1792,
    parameter int EXPIRE = 2048
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             arm,
    input logic             disarm,
    input logic             kick,
    input logic             halt,
    input logic             nmi,
    input logic             rst_req,
    input logic [CNT_W-1:0] count
);

    // R2
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !kick && !disarm) |=> $stable(count));

    // R3
    warn_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi |=> !nmi);

    // R3
    warn_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi |-> (count == CNT_W'(WARN)));

    // R4
    expire_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (count == '0));

    // R4
    expire_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R5
    kick_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (count == '0));

    // R6
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !kick && !disarm && !arm) |=> ($stable(count) && !nmi && !rst_req));

    // R7
    disarm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disarm |=> (count == '0));

    // R9
    in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(count) < EXPIRE);

endmodule

bind wdt_early_warn wdt_chk #(
    .CNT_W  (CNT_W),
    .WARN   (WARN_TICKS),
    .EXPIRE (EXPIRE_TICKS)
) u_wdt_chk (
    .clk     (clk_i),
    .rst_n   (rst_ni),
    .tick    (tick_i),
    .arm     (arm_i),
    .disarm  (disarm_i),
    .kick    (kick_i),
    .halt    (dbg_halt_i),
    .nmi     (nmi_pulse_o),
    .rst_req (rst_req_o),
    .count   (count_o)
);

// File: tb/tb_wdt_early_warn.sv
`timescale 1ns/1ps
module tb_wdt_early_warn;

    localparam int WARN   = 1792;
    localparam int EXPIRE = 2048;
    localparam int CW     = $clog2(EXPIRE);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, arm = 1'b0, disarm = 1'b0, kick = 1'b0, halt = 1'b0;
    logic nmi, rreq;
    logic [CW-1:0] cnt;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    wdt_early_warn #(.WARN_TICKS(WARN), .EXPIRE_TICKS(EXPIRE)) dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .tick_i      (tick),
        .arm_i       (arm),
        .disarm_i    (disarm),
        .kick_i      (kick),
        .dbg_halt_i  (halt),
        .nmi_pulse_o (nmi),
        .rst_req_o   (rreq),
        .count_o     (cnt)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_arm();
        arm = 1'b1; cyc(1); arm = 1'b0;
    endtask

    task automatic fresh();
        disarm = 1'b1; cyc(1); disarm = 1'b0;
        tick = 1'b1;
        do_arm();
    endtask

    task automatic t_reset();
        chk(cnt == 0, "R1 count", int'(cnt), 0);
        chk(nmi == 0, "R1 nmi", int'(nmi), 0);
        chk(rreq == 0, "R1 rst_req", int'(rreq), 0);
        tick = 1'b1; cyc(10);
        chk(cnt == 0, "R1 no count before enable", int'(cnt), 0);
    endtask

    task automatic t_count();
        fresh();
        cyc(5);
        chk(cnt == 5, "R2 steady ticks", int'(cnt), 5);
        tick = 1'b0; cyc(7);
        chk(cnt == 5, "R2 no tick holds", int'(cnt), 5);
        for (int i = 0; i < 10; i++) begin
            tick = i[0]; cyc(1);
        end
        chk(cnt == 10, "R2 alternating ticks", int'(cnt), 10);
        tick = 1'b1;
    endtask

    task automatic t_warn_expire();
        int nw, nr;
        fresh();
        cyc(WARN - 1);
        chk(cnt == WARN - 1, "R3 count before warn", int'(cnt), WARN - 1);
        chk(nmi == 0, "R3 nmi early", int'(nmi), 0);
        cyc(1);
        chk(nmi == 1, "R3 nmi at threshold", int'(nmi), 1);
        chk(cnt == WARN, "R3 count at warn", int'(cnt), WARN);
        cyc(1);
        chk(nmi == 0, "R3 nmi one cycle", int'(nmi), 0);
        cyc(EXPIRE - 1 - (WARN + 1));
        chk(cnt == EXPIRE - 1, "R9 top count", int'(cnt), EXPIRE - 1);
        chk(rreq == 0, "R4 no early reset", int'(rreq), 0);
        cyc(1);
        chk(rreq == 1, "R4 reset request", int'(rreq), 1);
        chk(cnt == 0, "R4 count wraps", int'(cnt), 0);
        cyc(1);
        chk(rreq == 0, "R4 reset one cycle", int'(rreq), 0);
        chk(cnt == 1, "R4 keeps counting", int'(cnt), 1);
        nw = 0; nr = 0;
        for (int i = 0; i < EXPIRE - 1; i++) begin
            cyc(1);
            if (nmi) nw++;
            if (rreq) nr++;
        end
        chk(nw == 1, "R3 one warning per interval", nw, 1);
        chk(nr == 1, "R4 one reset per interval", nr, 1);
    endtask

    task automatic t_restart();
        fresh();
        cyc(1000);
        kick = 1'b1; cyc(1); kick = 1'b0;
        chk(cnt == 0, "R5 restart clears", int'(cnt), 0);
        cyc(WARN);
        chk(nmi == 1, "R5 warning after restart", int'(nmi), 1);
        cyc(200);
        kick = 1'b1; cyc(1); kick = 1'b0;
        chk(cnt == 0, "R5 restart after warning", int'(cnt), 0);
        cyc(WARN - 1);
        chk(nmi == 0, "R5 no early rewarn", int'(nmi), 0);
        cyc(1);
        chk(nmi == 1, "R5 warning rearmed", int'(nmi), 1);
    endtask

    task automatic t_halt();
        int seen;
        fresh();
        cyc(WARN - 3);
        halt = 1'b1;
        seen = 0;
        for (int i = 0; i < 20; i++) begin
            cyc(1);
            if (nmi || rreq) seen++;
        end
        chk(cnt == WARN - 3, "R6 halt freezes count", int'(cnt), WARN - 3);
        chk(seen == 0, "R6 no request while halted", seen, 0);
        halt = 1'b0;
        cyc(3);
        chk(cnt == WARN, "R6 resumes after halt", int'(cnt), WARN);
        chk(nmi == 1, "R6 warning after resume", int'(nmi), 1);
    endtask

    task automatic t_disable();
        fresh();
        cyc(50);
        arm = 1'b1; disarm = 1'b1; cyc(1); arm = 1'b0; disarm = 1'b0;
        chk(cnt == 0, "R7 disable clears", int'(cnt), 0);
        cyc(10);
        chk(cnt == 0, "R7 disable beats enable", int'(cnt), 0);
        kick = 1'b1; cyc(5); kick = 1'b0;
        cyc(3);
        chk(cnt == 0, "R8 restart while disabled", int'(cnt), 0);
        chk(rreq == 0 && nmi == 0, "R8 no request", int'(rreq | nmi), 0);
        do_arm();
        cyc(4);
        chk(cnt == 4, "R7 re-enable counts", int'(cnt), 4);
    endtask

    initial begin
        #400000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        cyc(4);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_count();
        t_warn_expire();
        t_restart();
        t_halt();
        t_disable();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule